// File: doc/BRIEF.md
# Audio Sample Padding Adapter

This block sits between a memory-side stream of 32-bit words and a serializer-side stream of audio samples, with one lane for each direction. On the playback lane each incoming word carries a left-aligned sample. The block drops the low padding bits so that the sample leaves right-aligned. On the capture lane each incoming word carries a sample in its low bits. The block fills the high padding bits with copies of the sample's sign bit, so that the memory side receives a full two's-complement word.

Both lanes count channels within a frame. Each lane marks the last channel of every frame with a flag that travels alongside the data. The pad counts and the frame length come from one 32-bit configuration word. Each lane has a single register stage with a valid/ready handshake on both of its sides, and the two lanes stall independently.

Top module: `sample_pad_adapter`

## Requirements
- R1: A playback word accepted on the input appears on the playback output on the next cycle, shifted right (logically, with zero fill) by the pad count in configuration bits 4:0.
- R2: A capture word accepted on the input appears on the capture output on the next cycle. With pad count P from configuration bits 12:8, the low 32-P bits are copied from the input and the top P bits all equal input bit 31-P.
- R3: The frame length N is taken from configuration bits 22:20, with a value of 0 treated as 1 and values above 4 treated as 4. Each lane raises its last flag on a beat when the beats accepted since that lane's previous flagged beat, counting this one, reach N. When N is lowered mid-frame so that the count already reaches it, the next beat is flagged.
- R4: While an output is valid and not taken, its data and last flag stay unchanged, and that lane's input ready is low.
- R5: A stall on one lane's output has no effect on the acceptance or the results of the other lane.
- R6: Configuration bits outside 4:0, 12:8 and 22:20, including 6:5 and 14:13, have no effect on any output.
- R7: After reset both outputs are invalid, both input readies are high, and the next beat on each lane is the first channel of a frame.
- R8: A pad count of 0 passes the word unchanged on both lanes. A pad count of 31 leaves only input bit 31 at output bit 0 on playback, and makes every output bit equal input bit 0 on capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Pad counts and frame length |
| txInValid | input | 1 | Playback word valid |
| txInReady | output | 1 | Playback word accepted when high |
| txInData | input | 32 | Left-aligned playback word |
| txOutValid | output | 1 | Playback sample valid |
| txOutReady | input | 1 | Serializer takes the playback sample |
| txOutData | output | 32 | Right-aligned playback sample |
| txOutLast | output | 1 | Last channel of the frame |
| rxInValid | input | 1 | Captured sample valid |
| rxInReady | output | 1 | Captured sample accepted when high |
| rxInData | input | 32 | Captured sample in the low bits |
| rxOutValid | output | 1 | Padded capture word valid |
| rxOutReady | input | 1 | Memory side takes the capture word |
| rxOutData | output | 32 | Sign-extended capture word |
| rxOutLast | output | 1 | Last channel of the frame |

## Verification
The case hardest to reach from the ports is a change of frame length in the middle of a frame, because the lane's count then sits at or above the new length. The bench draws a new configuration word for every beat. That word has random pad counts, a random frame-length field that includes 0 and values above 4, and random bits elsewhere. Shortened frames therefore occur many times, and each one is compared with a model of the counting rule. A directed section stalls the playback output while capture beats keep flowing, which shows that the hold on one lane and the progress on the other coexist.

// File: rtl/pad_adapter_pkg.sv
package pad_adapter_pkg;
  localparam int WORD_W      = 32;
  localparam int PAD_W       = 5;
  localparam int CNT_FIELD_W = 3;
  localparam int TX_PAD_LSB  = 0;
  localparam int RX_PAD_LSB  = 8;
  localparam int CNT_LSB     = 20;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txLast;
    logic rxLoad;
    logic rxLast;
  } padStrobes_t;
endpackage

// File: rtl/pad_adapter_ctrl.sv
module pad_adapter_ctrl
  import pad_adapter_pkg::*;
#(
  parameter int MAX_CHANS   = 4,
  parameter int FIELD_W     = CNT_FIELD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] chanField,
  input  logic               txInValid,
  input  logic               txOutReady,
  input  logic               rxInValid,
  input  logic               rxOutReady,
  output logic               txInReady,
  output logic               txOutValid,
  output logic               rxInReady,
  output logic               rxOutValid,
  output padStrobes_t        strobes
);
  localparam int CW    = $clog2(MAX_CHANS) + 1;
  localparam int LANES = 2;

  logic [CW-1:0] effChans;

  always_comb begin
    if (chanField == '0)
      effChans = CW'(1);
    else if (int'(chanField) > MAX_CHANS)
      effChans = CW'(MAX_CHANS);
    else
      effChans = CW'(chanField);
  end

  logic [LANES-1:0] inValid, outReady, inReady, outValid, load, last;

  assign inValid  = {rxInValid, txInValid};
  assign outReady = {rxOutReady, txOutReady};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] chanCnt;
    logic          validQ;

    assign inReady[g]  = !validQ || outReady[g];
    assign load[g]     = inValid[g] && inReady[g];
    assign last[g]     = (chanCnt >= (effChans - CW'(1)));
    assign outValid[g] = validQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanCnt <= '0;
        validQ  <= 1'b0;
      end else begin
        if (load[g]) begin
          chanCnt <= last[g] ? '0 : chanCnt + CW'(1);
          validQ  <= 1'b1;
        end else if (outReady[g]) begin
          validQ  <= 1'b0;
        end
      end
    end
  end

  assign txInReady  = inReady[0];
  assign rxInReady  = inReady[1];
  assign txOutValid = outValid[0];
  assign rxOutValid = outValid[1];

  assign strobes.txLoad = load[0];
  assign strobes.txLast = last[0];
  assign strobes.rxLoad = load[1];
  assign strobes.rxLast = last[1];
endmodule

// File: rtl/pad_adapter_dp.sv
module pad_adapter_dp
  import pad_adapter_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int PW = PAD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  padStrobes_t   strobes,
  input  logic [PW-1:0] txPad,
  input  logic [PW-1:0] rxPad,
  input  logic [DW-1:0] txInData,
  input  logic [DW-1:0] rxInData,
  output logic [DW-1:0] txOutData,
  output logic          txOutLast,
  output logic [DW-1:0] rxOutData,
  output logic          rxOutLast
);
  localparam logic [PW-1:0] TOP_IDX = PW'(DW - 1);

  logic [DW-1:0] txShifted, keepMask, rxExtended;
  logic [PW-1:0] signIdx;
  logic          signBit;

  always_comb begin
    txShifted  = txInData >> txPad;
    keepMask   = {DW{1'b1}} >> rxPad;
    signIdx    = TOP_IDX - rxPad;
    signBit    = rxInData[signIdx];
    rxExtended = (rxInData & keepMask) | (signBit ? ~keepMask : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOutData <= '0;
      txOutLast <= 1'b0;
      rxOutData <= '0;
      rxOutLast <= 1'b0;
    end else begin
      if (strobes.txLoad) begin
        txOutData <= txShifted;
        txOutLast <= strobes.txLast;
      end
      if (strobes.rxLoad) begin
        rxOutData <= rxExtended;
        rxOutLast <= strobes.rxLast;
      end
    end
  end
endmodule

// File: rtl/sample_pad_adapter.sv
module sample_pad_adapter
  import pad_adapter_pkg::*;
#(
  parameter int MAX_CHANS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic              txInValid,
  output logic              txInReady,
  input  logic [WORD_W-1:0] txInData,
  output logic              txOutValid,
  input  logic              txOutReady,
  output logic [WORD_W-1:0] txOutData,
  output logic              txOutLast,
  input  logic              rxInValid,
  output logic              rxInReady,
  input  logic [WORD_W-1:0] rxInData,
  output logic              rxOutValid,
  input  logic              rxOutReady,
  output logic [WORD_W-1:0] rxOutData,
  output logic              rxOutLast
);
  padStrobes_t strobes;

  logic [PAD_W-1:0]       txPad, rxPad;
  logic [CNT_FIELD_W-1:0] chanField;
  logic                   unusedCfgBits;

  assign txPad     = cfgWord[TX_PAD_LSB +: PAD_W];
  assign rxPad     = cfgWord[RX_PAD_LSB +: PAD_W];
  assign chanField = cfgWord[CNT_LSB +: CNT_FIELD_W];
  assign unusedCfgBits = ^{cfgWord[7:5], cfgWord[19:13], cfgWord[31:23]};

  pad_adapter_ctrl #(.MAX_CHANS(MAX_CHANS), .FIELD_W(CNT_FIELD_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .chanField  (chanField),
    .txInValid  (txInValid),
    .txOutReady (txOutReady),
    .rxInValid  (rxInValid),
    .rxOutReady (rxOutReady),
    .txInReady  (txInReady),
    .txOutValid (txOutValid),
    .rxInReady  (rxInReady),
    .rxOutValid (rxOutValid),
    .strobes    (strobes)
  );

  pad_adapter_dp #(.DW(WORD_W), .PW(PAD_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .txPad     (txPad),
    .rxPad     (rxPad),
    .txInData  (txInData),
    .rxInData  (rxInData),
    .txOutData (txOutData),
    .txOutLast (txOutLast),
    .rxOutData (rxOutData),
    .rxOutLast (rxOutLast)
  );
endmodule

// File: rtl/pad_adapter_chk.sv
module pad_adapter_chk
  import pad_adapter_pkg::*;
#(
  parameter int MAX_CHANS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              txInValid,
  input logic              txInReady,
  input logic              txOutValid,
  input logic              txOutReady,
  input logic [WORD_W-1:0] txOutData,
  input logic              txOutLast,
  input logic              rxInValid,
  input logic              rxInReady,
  input logic              rxOutValid,
  input logic              rxOutReady,
  input logic [WORD_W-1:0] rxOutData,
  input logic              rxOutLast
);
  localparam int BW = $clog2(MAX_CHANS) + 2;

  logic [BW-1:0] txBeats, rxBeats;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBeats <= '0;
      rxBeats <= '0;
    end else begin
      if (txOutValid && txOutReady) txBeats <= txOutLast ? '0 : txBeats + BW'(1);
      if (rxOutValid && rxOutReady) rxBeats <= rxOutLast ? '0 : rxBeats + BW'(1);
    end
  end

  a_r1_tx_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    txInValid && txInReady |=> txOutValid);

  a_r2_rx_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rxInValid && rxInReady |=> rxOutValid);

  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    txOutValid && !txOutReady |=> txOutValid && $stable(txOutData) && $stable(txOutLast));

  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    rxOutValid && !rxOutReady |=> rxOutValid && $stable(rxOutData) && $stable(rxOutLast));

  a_r3_tx_frame_len: assert property (@(posedge clk) disable iff (!rstN)
    int'(txBeats) < MAX_CHANS);

  a_r3_rx_frame_len: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxBeats) < MAX_CHANS);
endmodule

bind sample_pad_adapter pad_adapter_chk #(.MAX_CHANS(MAX_CHANS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .txInValid  (txInValid),
  .txInReady  (txInReady),
  .txOutValid (txOutValid),
  .txOutReady (txOutReady),
  .txOutData  (txOutData),
  .txOutLast  (txOutLast),
  .rxInValid  (rxInValid),
  .rxInReady  (rxInReady),
  .rxOutValid (rxOutValid),
  .rxOutReady (rxOutReady),
  .rxOutData  (rxOutData),
  .rxOutLast  (rxOutLast)
);

// File: tb/sample_pad_adapter_tb_top.sv
module sample_pad_adapter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic txInValid = 1'b0, txOutReady = 1'b1, rxInValid = 1'b0, rxOutReady = 1'b1;
  logic [31:0] txInData = '0, rxInData = '0;
  logic txInReady, txOutValid, txOutLast, rxInReady, rxOutValid, rxOutLast;
  logic [31:0] txOutData, rxOutData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int txCnt = 0;
  int rxCnt = 0;

  always #5 clk = ~clk;

  sample_pad_adapter dut_i (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord),
    .txInValid(txInValid), .txInReady(txInReady), .txInData(txInData),
    .txOutValid(txOutValid), .txOutReady(txOutReady), .txOutData(txOutData), .txOutLast(txOutLast),
    .rxInValid(rxInValid), .rxInReady(rxInReady), .rxInData(rxInData),
    .rxOutValid(rxOutValid), .rxOutReady(rxOutReady), .rxOutData(rxOutData), .rxOutLast(rxOutLast)
  );

  function automatic logic [31:0] mkCfg(int tp, int rp, int ch, logic [31:0] other);
    logic [31:0] c;
    c = other & ~32'h0070_1F1F;
    c[4:0] = 5'(tp);
    c[12:8] = 5'(rp);
    c[22:20] = 3'(ch);
    return c;
  endfunction

  function automatic int frameLen(logic [31:0] c);
    int f = int'(c[22:20]);
    if (f == 0) return 1;
    if (f > 4) return 4;
    return f;
  endfunction

  function automatic logic [31:0] expTx(logic [31:0] d, logic [31:0] c);
    return d >> c[4:0];
  endfunction

  function automatic logic [31:0] expRx(logic [31:0] d, logic [31:0] c);
    logic [31:0] r;
    int p = int'(c[12:8]);
    for (int i = 0; i < 32; i++)
      r[i] = (i >= 32 - p) ? d[31 - p] : d[i];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one beat on either or both lanes; outputs checked one cycle after acceptance
  task automatic beat(logic [31:0] c, bit doTx, logic [31:0] td, bit doRx, logic [31:0] rd, string tag);
    logic [32:0] et, er;
    bit tl, rl;
    @(negedge clk);
    cfgWord = c; txInValid = doTx; txInData = td; rxInValid = doRx; rxInData = rd;
    tl = (txCnt >= frameLen(c) - 1);
    rl = (rxCnt >= frameLen(c) - 1);
    @(posedge clk);
    @(negedge clk);
    txInValid = 0; rxInValid = 0;
    if (doTx) begin
      et = {tl, expTx(td, c)};
      check(txOutValid && {txOutLast, txOutData} === et, {tag, " tx"}, {txOutLast, txOutData}, et);
      txCnt = tl ? 0 : txCnt + 1;
    end
    if (doRx) begin
      er = {rl, expRx(rd, c)};
      check(rxOutValid && {rxOutLast, rxOutData} === er, {tag, " rx"}, {rxOutLast, rxOutData}, er);
      rxCnt = rl ? 0 : rxCnt + 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    check(!txOutValid && !rxOutValid && txInReady && rxInReady, "R7 reset",
          {29'd0, txOutValid, rxOutValid, txInReady, rxInReady}, 33'h3);
    rstN = 1'b1;

    // R7: first beats start a frame of 2
    beat(mkCfg(16, 8, 2, 0), 1, 32'hABCD_0000, 1, 32'h0080_0000, "R7 first beat");
    beat(mkCfg(16, 8, 2, 0), 1, 32'h1234_5600, 1, 32'h007F_FFFF, "R3 second beat");

    // R8: pad extremes
    beat(mkCfg(0, 0, 1, 0), 1, 32'hDEAD_BEEF, 1, 32'h8765_4321, "R8 pad0");
    beat(mkCfg(31, 31, 1, 0), 1, 32'h8000_0000, 1, 32'h0000_0001, "R8 pad31 set");
    beat(mkCfg(31, 31, 1, 0), 1, 32'h7FFF_FFFF, 1, 32'hFFFF_FFFE, "R8 pad31 clear");

    // R1/R2: common widths, frame of 4
    for (int i = 0; i < 4; i++)
      beat(mkCfg(8, 16, 4, 0), 1, 32'hF0E0_D000 + i, 1, 32'h0000_8000 + i, "R1 R2 frame4");

    // R3: field 7 clamps to 4, lowering mid-frame flags next beat
    for (int i = 0; i < 3; i++)
      beat(mkCfg(8, 8, 7, 0), 1, 32'h1111_1100, 1, 32'h0011_1111, "R3 clamp");
    beat(mkCfg(8, 8, 2, 0), 1, 32'h2222_2200, 1, 32'h0022_2222, "R3 shrink");

    // R6: junk in unused bits, including sub-channel fields
    beat(mkCfg(16, 16, 1, 32'hFF8F_E0E0), 1, 32'hCAFE_0000, 1, 32'h0000_CAFE, "R6 unused bits");

    // R4 R5: stall playback output while capture flows
    beat(mkCfg(4, 4, 1, 0), 1, 32'h5555_AAA0, 0, 0, "R4 prime");
    held = expTx(32'h5555_AAA0, mkCfg(4, 4, 1, 0));
    beat(mkCfg(4, 4, 1, 0), 0, 0, 0, 0, "idle");
    @(negedge clk);
    txOutReady = 0;
    beat(mkCfg(4, 4, 1, 0), 1, 32'h9999_0000, 0, 0, "R4 stalled load");
    held = expTx(32'h9999_0000, mkCfg(4, 4, 1, 0));
    @(negedge clk);
    txInValid = 1; txInData = 32'h7777_7770;
    #1;
    check(!txInReady, "R4 ready low", {32'd0, txInReady}, 33'd0);
    txInValid = 0;
    beat(mkCfg(4, 4, 1, 0), 0, 0, 1, 32'h0800_0000, "R5 rx during stall");
    check(txOutValid && txOutData === held, "R4 tx held", {txOutValid, txOutData}, {1'b1, held});
    txOutReady = 1;
    @(negedge clk);
    check(!txOutValid, "R4 drained", {32'd0, txOutValid}, 33'd0);

    // random mix, new configuration every beat
    for (int i = 0; i < 400; i++)
      beat(mkCfg($urandom % 32, $urandom % 32, $urandom % 8, $urandom),
           1'($urandom), $urandom, 1'($urandom), $urandom, "R1 R2 R3 R6 random");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule